// File: doc/BRIEF.md
# Prioritized Memory Protection Region Checker

This block checks every bus access against eight programmable protection regions. Each region has a base address, a power-of-two size from 4 KB up to the whole 4 GB space, an enable bit, a cacheable bit, a bufferable bit and a two-bit permission code. Regions may overlap. When several regions contain the address, the region with the highest index wins. The block then reports that region's index and its cacheable and bufferable attributes, or raises an abort.

An abort is raised when no enabled region contains the address, or when the winning region's permission code forbids the access. The permission check uses the access's read/write flag and its privileged/user flag. Software programs a whole region in one cycle through a register-write port. Requests are accepted on any cycle that the valid signal is high. The result is registered and appears on the following clock cycle.

Top module: `mpu_region_check`

## Requirements
- R1: A write with `wr_en` high replaces the base, size code, enable, C, B and permission fields of the region selected by `wr_idx` (0 to 7), and leaves the other regions unchanged.
- R2: Size code N selects a region of 2^(N+1) bytes and is valid for N = 11 to 31. A code below 11 disables the region. Base bits below the region size are ignored, so the region covers the aligned block that contains the base.
- R3: A region whose enable bit is 0 never matches. Reset clears every enable bit, so every access aborts until a region is programmed.
- R4: When several enabled regions contain the address, the highest-numbered one wins. `rsp_region` shows its index and `rsp_hit` is 1.
- R5: The permission code works as follows: 0 allows no access; 1 allows privileged read and write only; 2 allows privileged read and write plus user read; 3 allows any access. The flags are `req_write`=1 for a write and `req_priv`=1 for a privileged access.
- R6: An access that matches no enabled region, or that the winning region's permission code forbids, gives `rsp_abort`=1 with `rsp_cacheable`=`rsp_bufferable`=0. With no match, `rsp_hit`=0 and `rsp_region`=0. With a permission abort, `rsp_hit`=1 and `rsp_region` shows the winning index.
- R7: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and the response fields belong to that request. `rsp_valid` is 0 during and after reset until a request arrives.
- R8: A region write in the same cycle as a request does not affect that request. It takes effect from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Region write strobe |
| wr_idx | input | 3 | Region selected for write |
| wr_base | input | 32 | Base address to store |
| wr_size | input | 5 | Size code N (2^(N+1) bytes) |
| wr_enable | input | 1 | Region enable bit |
| wr_cacheable | input | 1 | Cacheable attribute |
| wr_bufferable | input | 1 | Bufferable attribute |
| wr_perm | input | 2 | Permission code |
| req_valid | input | 1 | Access request valid |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_hit | output | 1 | Some enabled region matched |
| rsp_region | output | 3 | Winning region index |
| rsp_cacheable | output | 1 | Winning region C bit (0 on abort) |
| rsp_bufferable | output | 1 | Winning region B bit (0 on abort) |
| rsp_abort | output | 1 | Access aborted |

## Verification
The address patterns place one small region inside a larger one, and a 4 GB background region under both. This tells apart the priority winner from its lower-numbered neighbours, and probes addresses just inside and just outside each edge. An unaligned base and an out-of-range size code show whether low base bits are masked and whether an invalid size really disables a region. The permission tests try every mix of read/write and user/privileged against each code. A region write that lands in the same cycle as a request shows whether that request still sees the old registers.

// File: rtl/mpu_pkg.sv
// Package: shared widths and the region record used by the protection checker.
// Assumes a byte-addressed space of ADDR_W bits.
package mpu_pkg;
    parameter int ADDR_W        = 32;
    parameter int SIZE_W        = 5;
    parameter int PERM_W        = 2;
    parameter int MIN_SIZE_CODE = 11;

    typedef enum logic [PERM_W-1:0] {
        PERM_NONE      = 2'd0,
        PERM_PRIV_ONLY = 2'd1,
        PERM_USER_RO   = 2'd2,
        PERM_FULL      = 2'd3
    } perm_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic              c;
        logic              b;
        perm_e             perm;
    } region_t;
endpackage

// File: rtl/mpu_region_regs.sv
// Module: holds the programmable region records.
// Assumes at most one write per cycle. Reset clears only the enable bits.
module mpu_region_regs
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  region_t           wr_rec,
    output region_t           regions [NUM_REGIONS]
);
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
        // Update one region record on a matching write; clear enable on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regions[i].en <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                regions[i] <= wr_rec;
            end
        end

        AST_RESET_CLEARS_EN: assert property (@(posedge clk)
            !rst_n |=> !regions[i].en); // R3
    end
endmodule

// File: rtl/mpu_region_match.sv
// Module: decides whether one region covers an address.
// Assumes the size code means 2^(N+1) bytes. Codes below MIN_SIZE_CODE disable the region.
module mpu_region_match
    import mpu_pkg::*;
(
    input  region_t           rec,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [SIZE_W:0]   shift_amt;
    logic [ADDR_W-1:0] mask;
    logic              size_ok;

    // Build the mask of address bits above the region size and compare them.
    always_comb begin
        shift_amt = {1'b0, rec.size} + (SIZE_W+1)'(1);
        mask      = {ADDR_W{1'b1}} << shift_amt;
        size_ok   = rec.size >= SIZE_W'(MIN_SIZE_CODE);
        hit       = rec.en && size_ok && ((addr & mask) == (rec.base & mask));
    end
endmodule

// File: rtl/mpu_priority_pick.sv
// Module: picks the highest-numbered set bit of a match vector.
// Assumes a higher index means a higher priority.
module mpu_priority_pick #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] match,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);
    // Scan upward so that the last match found, the highest index, wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // Check that the winner is a real match with no higher match above it.
    always_comb begin
        if (any) begin
            AST_WIN_IS_MATCH: assert (match[idx]); // R4
            AST_NO_HIGHER_MATCH: assert (((match >> idx) >> 1) == '0); // R4
        end
    end
endmodule

// File: rtl/mpu_perm_check.sv
// Module: decides whether an access may proceed under a permission code.
// Assumes priv=1 for privileged and write=1 for a write.
module mpu_perm_check
    import mpu_pkg::*;
(
    input  perm_e perm,
    input  logic  write,
    input  logic  priv,
    output logic  allow
);
    // Decode the permission code against the access kind.
    always_comb begin
        unique case (perm)
            PERM_NONE:      allow = 1'b0;
            PERM_PRIV_ONLY: allow = priv;
            PERM_USER_RO:   allow = priv || !write;
            PERM_FULL:      allow = 1'b1;
            default:        allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/mpu_region_check.sv
// Module: top of the protection checker. It matches the address against all regions,
// resolves overlaps by priority, checks permission and registers the result.
// Assumes the request lasts one cycle. Region writes apply at the same edge as the
// request is sampled, so that request sees the old records.
module mpu_region_check
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_enable,
    input  logic              wr_cacheable,
    input  logic              wr_bufferable,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_region,
    output logic              rsp_cacheable,
    output logic              rsp_bufferable,
    output logic              rsp_abort
);
    region_t                regions [NUM_REGIONS];
    region_t                wr_rec;
    logic [NUM_REGIONS-1:0] match;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    region_t                win_rec;
    logic                   allow;
    logic                   abort_n;

    // Gather the write-port fields into one record.
    always_comb begin
        wr_rec = '{en: wr_enable, base: wr_base, size: wr_size, c: wr_cacheable,
                   b: wr_bufferable, perm: perm_e'(wr_perm)};
    end

    mpu_region_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_rec(wr_rec), .regions(regions)
    );

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_match
        mpu_region_match u_match (
            .rec(regions[i]), .addr(req_addr), .hit(match[i])
        );
    end

    mpu_priority_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
        .match(match), .any(any_hit), .idx(win_idx)
    );

    // Select the winning region record.
    always_comb begin
        win_rec = regions[win_idx];
    end

    mpu_perm_check u_perm (
        .perm(win_rec.perm), .write(req_write), .priv(req_priv), .allow(allow)
    );

    // An access passes only when some region matched and its permission allows it.
    always_comb begin
        abort_n = any_hit && allow;
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_region     <= '0;
            rsp_cacheable  <= 1'b0;
            rsp_bufferable <= 1'b0;
            rsp_abort      <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit        <= any_hit;
                rsp_region     <= any_hit ? win_idx : '0;
                rsp_cacheable  <= abort_n && win_rec.c;
                rsp_bufferable <= abort_n && win_rec.b;
                rsp_abort      <= !abort_n;
            end
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R7
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R7
    AST_ABORT_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> !rsp_cacheable && !rsp_bufferable); // R6
    AST_MISS_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_abort); // R6
    AST_NONE_CODE_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_hit && win_rec.perm == PERM_NONE) |=> rsp_abort); // R5
endmodule

// File: tb/mpu_region_check_bench.sv
`timescale 1ns/100ps
module mpu_region_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_base = '0;
    logic [4:0]  wr_size = '0;
    logic        wr_enable = 1'b0, wr_cacheable = 1'b0, wr_bufferable = 1'b0;
    logic [1:0]  wr_perm = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0, req_priv = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_cacheable, rsp_bufferable, rsp_abort;
    logic [2:0]  rsp_region;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    mpu_region_check u_mpu_region_check (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_size(wr_size), .wr_enable(wr_enable), .wr_cacheable(wr_cacheable),
        .wr_bufferable(wr_bufferable), .wr_perm(wr_perm), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_region(rsp_region),
        .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable),
        .rsp_abort(rsp_abort)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        priv;
        logic        hit;
        logic [2:0]  idx;
        logic        c;
        logic        b;
        logic        abort;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h1000_0000, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 8'd5},
        '{32'h1000_0000, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 8'd5},
        '{32'h2000_0004, 1'b1, 1'b0, 1'b1, 3'd2, 1'b1, 1'b1, 1'b0, 8'd2},
        '{32'h2010_0FFC, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 8'd4},
        '{32'h2010_0FFC, 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 8'd5},
        '{32'h2010_0FFC, 1'b1, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 8'd6},
        '{32'h2010_1000, 1'b1, 1'b0, 1'b1, 3'd2, 1'b1, 1'b1, 1'b0, 8'd2},
        '{32'h8000_FFFF, 1'b0, 1'b1, 1'b1, 3'd7, 1'b0, 1'b0, 1'b1, 8'd5},
        '{32'h8001_0000, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 8'd2},
        '{32'h4000_0000, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 8'd2},
        '{32'h6000_0000, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 8'd3},
        '{32'h1FFF_FFFF, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 8'd4}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] pack_rsp();
        return {rsp_valid, rsp_hit, rsp_region, rsp_cacheable, rsp_bufferable, rsp_abort};
    endfunction

    task automatic write_region(input logic [2:0] idx, input logic [31:0] base,
                                input logic [4:0] sz, input logic en, input logic c,
                                input logic b, input logic [1:0] perm);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_base = base; wr_size = sz;
        wr_enable = en; wr_cacheable = c; wr_bufferable = b; wr_perm = perm;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic request(input logic [31:0] a, input logic w, input logic p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_priv = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #900000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: no response while in reset
        check("R7 reset rsp_valid", {7'd0, rsp_valid}, 8'd0);
        rst_n = 1'b1;
        // R3: after reset every access aborts with no hit
        request(32'h1000_0000, 1'b0, 1'b1);
        check("R3 reset aborts", pack_rsp(), 8'b1_0_000_001);
        @(negedge clk);
        // R7: valid drops when no request
        check("R7 idle rsp_valid", {7'd0, rsp_valid}, 8'd0);

        // R1, R2: program the regions (perm code: 0 none, 1 priv, 2 user read, 3 full)
        write_region(3'd0, 32'h0000_0000, 5'd31, 1'b1, 1'b0, 1'b0, 2'd1);
        write_region(3'd2, 32'h2000_0000, 5'd27, 1'b1, 1'b1, 1'b1, 2'd3);
        write_region(3'd5, 32'h2010_0000, 5'd11, 1'b1, 1'b1, 1'b0, 2'd2);
        write_region(3'd7, 32'h8000_1234, 5'd15, 1'b1, 1'b0, 1'b1, 2'd0);
        write_region(3'd3, 32'h4000_0000, 5'd5,  1'b1, 1'b1, 1'b1, 2'd3);
        write_region(3'd4, 32'h6000_0000, 5'd20, 1'b0, 1'b1, 1'b1, 2'd3);

        // Walk the vector table: R2 R3 R4 R5 R6 via the tag stored per entry
        for (int i = 0; i < NV; i++) begin
            request(VECS[i].addr, VECS[i].wr, VECS[i].priv);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), pack_rsp(),
                  {1'b1, VECS[i].hit, VECS[i].idx, VECS[i].c, VECS[i].b, VECS[i].abort});
        end

        // R1: rewriting region 5 to full access leaves region 2 untouched
        write_region(3'd5, 32'h2010_0000, 5'd11, 1'b1, 1'b0, 1'b1, 2'd3);
        request(32'h2010_0010, 1'b1, 1'b0);
        check("R1 rewrite region 5", pack_rsp(), 8'b1_1_101_010);
        request(32'h2000_0000, 1'b1, 1'b0);
        check("R1 region 2 kept", pack_rsp(), 8'b1_1_010_110);

        // R8: a write in the same cycle as a request does not affect that request
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h9000_0000; req_write = 1'b0; req_priv = 1'b1;
        wr_en = 1'b1; wr_idx = 3'd6; wr_base = 32'h9000_0000; wr_size = 5'd12;
        wr_enable = 1'b1; wr_cacheable = 1'b1; wr_bufferable = 1'b1; wr_perm = 2'd3;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check("R8 same-cycle write old view", pack_rsp(), 8'b1_1_000_000);
        request(32'h9000_0000, 1'b0, 1'b1);
        check("R8 next request new view", pack_rsp(), 8'b1_1_110_110);

        // R6, R3: disable region 0 so an uncovered address misses entirely
        write_region(3'd0, 32'h0000_0000, 5'd31, 1'b0, 1'b1, 1'b1, 2'd3);
        request(32'h1000_0000, 1'b0, 1'b1);
        check("R6 no match abort", pack_rsp(), 8'b1_0_000_001);

        // R7: back-to-back requests each get their own response
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h9000_0000;
        @(negedge clk);
        check("R7 back-to-back first", pack_rsp(), 8'b1_1_110_110);
        req_addr = 32'h1000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 back-to-back second", pack_rsp(), 8'b1_0_000_001);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule